// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander

This block is an I2C slave that gives a host eight general-purpose pins without any direction register. Every pin is quasi-bidirectional: a stored 0 pulls it hard to ground, and a stored 1 lets a weak pull-up hold it high. An external device can pull a released pin low, so software writes a 1 to a pin it wants to read. A short strong pull-up pulse speeds the rising edges that a write produces. The block samples SCL and SDA with a fast system clock, finds START and STOP conditions, and answers a 7-bit address. The upper four bits of that address are fixed and the lower three come from strap inputs.

On a write, each byte after the address goes into the port latch. On a read, the pins are sampled and the sample is shifted back to the master. An active-low interrupt reports that the pins no longer match the last snapshot the block took. A read sample clears it, and the sample taken right after a write keeps the written value from raising it. A first byte of the form 0000_1xxx is a high-speed master code: the block does not acknowledge it, and it records the mode until the next STOP.

Top module: `i2c_qgpio_expander`

## Requirements
- R1: After reset, pin_weak_high is 8'hFF, pin_pull_low and pin_strong_high are 8'h00, irq_n is 1, sda_oe is 0 and hs_mode is 0.
- R2: The block acknowledges (sda_oe=1 during the ninth SCL pulse) only an address byte whose bits [7:4] are 4'b0100, whose bits [3:1] equal addr_strap and whose bit 0 is the R/W flag (0 write, 1 read). Any other address gets no acknowledge, and the data bytes that follow leave the port unchanged.
- R3: In a write, every data byte is acknowledged and is taken into the port latch on the SCL rising edge of its acknowledge bit. After that edge pin_weak_high equals the byte and pin_pull_low equals its inverse, and later bytes replace earlier ones.
- R4: pin_strong_high equals the latched byte from the acknowledge-bit SCL rising edge of a write data byte until the following SCL falling edge, and is 8'h00 at all other times.
- R5: A write never leaves irq_n low: the pins are captured as the new snapshot on the SCL falling edge that ends the write acknowledge bit.
- R6: A read returns the pin values MSB first. The pins are sampled on the SCL rising edge of the acknowledge bit after the address and after each data byte that the master acknowledges.
- R7: irq_n goes low when the synchronised pin values differ from the snapshot, and goes high again if they return to it.
- R8: Each read sample takes a new snapshot and drives irq_n high. If the master NACKs a read byte, no sample is taken and a pending interrupt remains.
- R9: A first byte after START of the form 0000_1xxx is not acknowledged and sets hs_mode. hs_mode stays 1 through repeated STARTs and is cleared by a STOP.
- R10: sda_oe changes only while SCL is low.
- R11: A repeated START ends the current transfer and begins a new address phase. A read that follows a write returns the value just written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| addr_strap | input | 3 | Low three bits of the slave address |
| pin_in | input | 8 | Levels present on the port pins |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| pin_pull_low | output | 8 | Strong pull-down enable per pin |
| pin_weak_high | output | 8 | Weak pull-up enable per pin |
| pin_strong_high | output | 8 | Short strong pull-up enable per pin |
| irq_n | output | 1 | Active-low pin-change interrupt |
| hs_mode | output | 1 | High-speed master code seen since last STOP |

## Verification
A vector table writes bytes while external loads pull chosen released pins low, then reads the pins back. Mixed bit patterns with and without loads show whether read data is the latched value masked by the loads, and whether the strong pull-up pulse follows only the 1 bits. Directed sequences cover a wrong strap address, multi-byte writes, a repeated START from write to read, and a pin change during a read that the master NACKs, which separates the clearing sample taken after the address from the missing sample after the NACK. A high-speed code followed by a normal transfer shows that the mode flag survives a repeated START but not a STOP.

// File: rtl/qgpio_pkg.sv
package qgpio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } bus_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/qgpio_line_sync.sv
module qgpio_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_q;
  logic              sda_q;

  // idle bus is high on both lines
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[STAGES-2:0], sda_i};
      scl_q     <= scl_chain[STAGES-1];
      sda_q     <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edge while the clock stays high
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/qgpio_port.sv
module qgpio_port #(
  parameter int PORT_W = 8,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] pin_in,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              snap_stb,
  input  logic              rd_stb,
  output logic [PORT_W-1:0] pin_sync,
  output logic [PORT_W-1:0] pin_pull_low,
  output logic [PORT_W-1:0] pin_weak_high,
  output logic [PORT_W-1:0] pin_strong_high,
  output logic              irq_n
);

  logic [PORT_W-1:0] pin_chain [STAGES];
  logic [PORT_W-1:0] latch_q;
  logic [PORT_W-1:0] snap_q;
  logic [PORT_W-1:0] strong_q;
  logic              hold_q;
  logic              irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) pin_chain[k] <= '1;
    end else begin
      pin_chain[0] <= pin_in;
      for (int k = 1; k < STAGES; k++) pin_chain[k] <= pin_chain[k-1];
    end
  end

  assign pin_sync = pin_chain[STAGES-1];

  // latch, strong pulse and the compare-hold window of a write
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q  <= '1;
      strong_q <= '0;
      hold_q   <= 1'b0;
    end else if (wr_stb) begin
      latch_q  <= wr_data;
      strong_q <= wr_data;
      hold_q   <= 1'b1;
    end else if (snap_stb) begin
      strong_q <= '0;
      hold_q   <= 1'b0;
    end
  end

  // snapshot and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '1;
      irq_q  <= 1'b1;
    end else if (snap_stb || rd_stb) begin
      snap_q <= pin_sync;
      irq_q  <= 1'b1;
    end else if (!hold_q && !wr_stb) begin
      irq_q  <= (pin_sync == snap_q);
    end
  end

  assign pin_pull_low    = ~latch_q;
  assign pin_weak_high   = latch_q;
  assign pin_strong_high = strong_q;
  assign irq_n           = irq_q;

  assert_latch_on_write_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(latch_q) |-> $past(wr_stb));

  assert_sample_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (snap_stb || rd_stb) |=> irq_n);

  assert_strong_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    (|strong_q) |-> hold_q);

endmodule

// File: rtl/qgpio_bus_fsm.sv
module qgpio_bus_fsm
  import qgpio_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          STRAP_W = 3,
  parameter logic [3:0]  ADDR_HI = 4'b0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  pin_sync,
  output logic               sda_oe,
  output logic               hs_mode,
  output logic               wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic               snap_stb,
  output logic               rd_stb
);

  localparam int          CNT_W   = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);
  localparam logic [4:0]  HS_CODE = 5'b00001;

  bus_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx;
  logic [DATA_W-1:0] tx;
  logic              rw_q;
  logic              acked_q;
  logic              oe_q;
  logic              hs_q;
  logic              addr_hit;

  assign addr_hit = (rx[DATA_W-1:1] == {ADDR_HI, strap});

  always_ff @(posedge clk) begin
    wr_stb   <= 1'b0;
    snap_stb <= 1'b0;
    rd_stb   <= 1'b0;
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rx      <= '0;
      tx      <= '0;
      wr_data <= '0;
      rw_q    <= 1'b0;
      acked_q <= 1'b0;
      oe_q    <= 1'b0;
      hs_q    <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
      hs_q  <= 1'b0;
    end else if (start_det) begin
      state <= ST_ADDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            rx  <= {rx[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            if (rx[DATA_W-1:DATA_W-5] == HS_CODE) begin
              hs_q  <= 1'b1;
              state <= ST_IGNORE;
            end else if (addr_hit) begin
              rw_q  <= rx[0];
              oe_q  <= 1'b1;
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_rise && rw_q) begin
            tx     <= pin_sync;
            rd_stb <= 1'b1;
          end else if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              oe_q  <= ~tx[DATA_W-1];
              tx    <= {tx[DATA_W-2:0], 1'b0};
              state <= ST_RD_DATA;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_WR_DATA;
            end
          end
        end
        ST_WR_DATA: begin
          if (scl_rise) begin
            rx  <= {rx[DATA_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == LAST) begin
            oe_q  <= 1'b1;
            state <= ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_rise) begin
            wr_stb  <= 1'b1;
            wr_data <= rx;
          end else if (scl_fall) begin
            snap_stb <= 1'b1;
            oe_q     <= 1'b0;
            cnt      <= '0;
            state    <= ST_WR_DATA;
          end
        end
        ST_RD_DATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST) begin
              oe_q  <= 1'b0;
              state <= ST_RD_ACK;
            end else begin
              oe_q <= ~tx[DATA_W-1];
              tx   <= {tx[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            acked_q <= ~sda_s;
            if (!sda_s) begin
              tx     <= pin_sync;
              rd_stb <= 1'b1;
            end
          end else if (scl_fall) begin
            cnt <= '0;
            if (acked_q) begin
              oe_q  <= ~tx[DATA_W-1];
              tx    <= {tx[DATA_W-2:0], 1'b0};
              state <= ST_RD_DATA;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe  = oe_q;
  assign hs_mode = hs_q;

  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !$past(scl_s));

  assert_hs_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (hs_q && !stop_det) |=> hs_q);

  assert_ack_matched_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(oe_q) && state == ST_ADDR_ACK) |-> $past(addr_hit));

endmodule

// File: rtl/i2c_qgpio_expander.sv
module i2c_qgpio_expander #(
  parameter int         PORT_W    = 8,
  parameter int         STRAP_W   = 3,
  parameter int         SYNC_LEN  = 2,
  parameter logic [3:0] ADDR_HIGH = 4'b0100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] addr_strap,
  input  logic [PORT_W-1:0]  pin_in,
  output logic               sda_oe,
  output logic [PORT_W-1:0]  pin_pull_low,
  output logic [PORT_W-1:0]  pin_weak_high,
  output logic [PORT_W-1:0]  pin_strong_high,
  output logic               irq_n,
  output logic               hs_mode
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_stb, snap_stb, rd_stb;
  logic [PORT_W-1:0] wr_data;
  logic [PORT_W-1:0] pin_sync;

  qgpio_line_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  qgpio_bus_fsm #(
    .DATA_W (PORT_W),
    .STRAP_W(STRAP_W),
    .ADDR_HI(ADDR_HIGH)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap    (addr_strap),
    .pin_sync (pin_sync),
    .sda_oe   (sda_oe),
    .hs_mode  (hs_mode),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .snap_stb (snap_stb),
    .rd_stb   (rd_stb)
  );

  qgpio_port #(.PORT_W(PORT_W), .STAGES(SYNC_LEN)) u_port (
    .clk            (clk),
    .rst            (rst),
    .pin_in         (pin_in),
    .wr_stb         (wr_stb),
    .wr_data        (wr_data),
    .snap_stb       (snap_stb),
    .rd_stb         (rd_stb),
    .pin_sync       (pin_sync),
    .pin_pull_low   (pin_pull_low),
    .pin_weak_high  (pin_weak_high),
    .pin_strong_high(pin_strong_high),
    .irq_n          (irq_n)
  );

endmodule

// File: tb/i2c_qgpio_expander_bench.sv
`timescale 1ns/1ps
module i2c_qgpio_expander_bench;

  localparam int HALF = 20;
  localparam logic [7:0] WR_ADDR = 8'h4A;  // 0100_101_0
  localparam logic [7:0] RD_ADDR = 8'h4B;  // 0100_101_1
  // {data byte, external pull-down mask}
  localparam logic [15:0] VEC [6] = '{16'hA5_00, 16'h3C_00, 16'hFF_21,
                                      16'h00_00, 16'hF0_80, 16'h5A_0F};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] ext_low = 8'h00;
  logic [2:0] strap = 3'b101;
  logic sda_line;
  logic [7:0] pin_in;
  logic sda_oe, irq_n, hs_mode;
  logic [7:0] pull_low, weak_high, strong_high;
  int checks = 0;
  int fails = 0;
  int oe_bad = 0;
  logic prev_oe = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign pin_in   = ~pull_low & ~ext_low;

  i2c_qgpio_expander u_i2c_qgpio_expander (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .addr_strap(strap), .pin_in(pin_in), .sda_oe(sda_oe),
    .pin_pull_low(pull_low), .pin_weak_high(weak_high),
    .pin_strong_high(strong_high), .irq_n(irq_n), .hs_mode(hs_mode)
  );

  // R10 monitor: enable may only move while SCL is low
  always @(negedge clk) begin
    if (!rst && sda_oe !== prev_oe && scl) oe_bad++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(HALF);
    scl = 1'b1;   tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl = 1'b0;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(HALF);
    scl = 1'b1;   tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack,
                           output logic [7:0] stg_mid, output logic [7:0] stg_after);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF);
      scl = 1'b1;   tick(HALF);
      scl = 1'b0;
    end
    sda_m = 1'b1; tick(HALF);
    scl = 1'b1;   tick(HALF/2);
    ack = ~sda_line;
    stg_mid = strong_high;
    tick(HALF/2);
    scl = 1'b0;   tick(HALF/2);
    stg_after = strong_high;
  endtask

  task automatic recv_byte(input logic do_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      tick(HALF);
      scl = 1'b1; tick(HALF/2);
      d[i] = sda_line;
      tick(HALF/2);
      scl = 1'b0;
    end
    sda_m = ~do_ack; tick(HALF);
    scl = 1'b1;      tick(HALF);
    scl = 1'b0;
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] sm, sa, d, d2;
    tick(5);
    rst = 1'b0;
    tick(10);

    // R1 reset state
    check(weak_high == 8'hFF, "R1 weak_high", weak_high, 8'hFF);
    check(pull_low == 8'h00, "R1 pull_low", pull_low, 8'h00);
    check(strong_high == 8'h00, "R1 strong_high", strong_high, 8'h00);
    check(irq_n == 1'b1 && sda_oe == 1'b0 && hs_mode == 1'b0, "R1 irq/sda/hs",
          {5'b0, irq_n, sda_oe, hs_mode}, 8'h04);

    // vector table: write, observe drive, read back
    for (int v = 0; v < 6; v++) begin
      logic [7:0] val, msk;
      val = VEC[v][15:8];
      msk = VEC[v][7:0];
      ext_low = msk;
      tick(10);
      bus_start;
      send_byte(WR_ADDR, ack, sm, sa);
      check(ack, "R2 write address ack", {7'b0, ack}, 8'h01);
      send_byte(val, ack, sm, sa);
      check(ack, "R3 data ack", {7'b0, ack}, 8'h01);
      check(sm == val, "R4 strong pulse during ack", sm, val);
      check(sa == 8'h00, "R4 strong released after ack", sa, 8'h00);
      bus_stop;
      tick(10);
      check(weak_high == val && pull_low == ~val, "R3 port drive", weak_high, val);
      check(irq_n == 1'b1, "R5 no irq from write", {7'b0, irq_n}, 8'h01);
      bus_start;
      send_byte(RD_ADDR, ack, sm, sa);
      recv_byte(1'b0, d);
      bus_stop;
      check(d == (val & ~msk), "R6 read pins", d, val & ~msk);
    end

    // multi-byte write, then repeated START into a read
    ext_low = 8'h00;
    tick(10);
    bus_start;
    send_byte(WR_ADDR, ack, sm, sa);
    send_byte(8'h12, ack, sm, sa);
    send_byte(8'h34, ack, sm, sa);
    bus_stop;
    tick(10);
    check(weak_high == 8'h34, "R3 last byte wins", weak_high, 8'h34);
    bus_start;
    send_byte(WR_ADDR, ack, sm, sa);
    send_byte(8'h77, ack, sm, sa);
    bus_start;
    send_byte(RD_ADDR, ack, sm, sa);
    check(ack, "R11 read address after repeated start", {7'b0, ack}, 8'h01);
    recv_byte(1'b0, d);
    bus_stop;
    check(d == 8'h77, "R11 read after repeated start", d, 8'h77);

    // wrong strap bits: no ack, port untouched
    bus_start;
    send_byte(8'h48, ack, sm, sa);
    check(!ack, "R2 mismatched address not acked", {7'b0, ack}, 8'h00);
    send_byte(8'h00, ack, sm, sa);
    check(!ack, "R2 data after mismatch not acked", {7'b0, ack}, 8'h00);
    bus_stop;
    tick(10);
    check(weak_high == 8'h77, "R2 port unchanged", weak_high, 8'h77);

    // pin change interrupt
    bus_start;
    send_byte(WR_ADDR, ack, sm, sa);
    send_byte(8'hFF, ack, sm, sa);
    bus_stop;
    ext_low = 8'h04;
    tick(10);
    check(irq_n == 1'b0, "R7 irq on change", {7'b0, irq_n}, 8'h00);
    ext_low = 8'h00;
    tick(10);
    check(irq_n == 1'b1, "R7 irq released on return", {7'b0, irq_n}, 8'h01);

    // read sample clears; NACK leaves pending interrupt
    ext_low = 8'h10;
    tick(10);
    check(irq_n == 1'b0, "R7 irq on second change", {7'b0, irq_n}, 8'h00);
    bus_start;
    send_byte(RD_ADDR, ack, sm, sa);
    tick(4);
    check(irq_n == 1'b1, "R8 address sample clears", {7'b0, irq_n}, 8'h01);
    ext_low = 8'h18;
    tick(10);
    recv_byte(1'b0, d);
    bus_stop;
    tick(10);
    check(d == 8'hEF, "R6 data from address sample", d, 8'hEF);
    check(irq_n == 1'b0, "R8 NACK keeps irq", {7'b0, irq_n}, 8'h00);
    bus_start;
    send_byte(RD_ADDR, ack, sm, sa);
    recv_byte(1'b1, d);
    recv_byte(1'b0, d2);
    bus_stop;
    tick(10);
    check(d == 8'hE7 && d2 == 8'hE7, "R6 acked byte resampled", d2, 8'hE7);
    check(irq_n == 1'b1, "R8 read clears irq", {7'b0, irq_n}, 8'h01);
    ext_low = 8'h00;
    tick(10);
    bus_start;
    send_byte(RD_ADDR, ack, sm, sa);
    recv_byte(1'b0, d);
    bus_stop;

    // high-speed master code
    bus_start;
    send_byte(8'h0B, ack, sm, sa);
    check(!ack, "R9 master code not acked", {7'b0, ack}, 8'h00);
    check(hs_mode == 1'b1, "R9 hs_mode set", {7'b0, hs_mode}, 8'h01);
    bus_start;
    send_byte(WR_ADDR, ack, sm, sa);
    check(ack, "R9 address acked in hs mode", {7'b0, ack}, 8'h01);
    send_byte(8'h55, ack, sm, sa);
    check(hs_mode == 1'b1, "R9 hs_mode across repeated start", {7'b0, hs_mode}, 8'h01);
    bus_stop;
    tick(10);
    check(hs_mode == 1'b0, "R9 hs_mode cleared by stop", {7'b0, hs_mode}, 8'h00);
    check(weak_high == 8'h55, "R9 write in hs mode", weak_high, 8'h55);

    check(oe_bad == 0, "R10 sda_oe moved with SCL high", 8'(oe_bad), 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule